// File: doc/BRIEF.md
# Two-Bit Branch Direction and Target Predictor

This block sits in the fetch stage of a pipelined processor. It tells fetch where to go next. A table of two-bit saturating counters holds the recent direction of each branch. The table is indexed by low-order bits of the fetch address. Next to it sits a small direct-mapped target cache. Each target entry is tagged with the upper address bits. Fetch reads both arrays combinationally in the same cycle it presents its address. It then receives a predicted-taken flag and the address to fetch next.

When a branch resolves later in the pipeline, the pipeline drives the update port. It supplies the branch address, the real outcome, the real target, and the prediction that fetch acted on. The block trains the counter. A taken branch also installs its target. In the same cycle the block flags a misprediction and gives the address to restart from, so the pipeline can flush the wrong-path instructions.

Two branches whose index bits are equal share one counter. This aliasing costs only accuracy, never correctness. A target miss always falls back to the sequential address, whatever the counter says.

Top module: `branch_predictor`

## Requirements
- R1: The counter index is `pc[DIR_IDX_W+1:2]`. The target-cache index is `pc[BTB_IDX_W+1:2]` and its tag is `pc[PC_W-1:BTB_IDX_W+2]`. Two addresses that differ only above bit DIR_IDX_W+1 share one counter.
- R2: After reset every counter holds 01 (weakly not taken) and every target entry is invalid. A single taken update is therefore enough to make the direction taken.
- R3: The counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken and 11 strongly taken. A taken update adds one and saturates at 11. A not-taken update subtracts one and saturates at 00.
- R4: The predicted direction is bit 1 of the counter. From a strong state, the direction changes only after two consecutive outcomes that disagree with it.
- R5: A target hit needs a valid entry whose stored tag equals the fetch tag. A taken update writes the tag and target into its entry, replacing any earlier entry. A not-taken update leaves the target cache unchanged.
- R6: `pred_taken` is high only when the direction is taken and the target cache hits. `pred_next_pc` is then the cached target, and otherwise `fetch_pc + 4`.
- R7: Updates take effect at the clock edge. A fetch read of the index being updated in the same cycle returns the value from before the update.
- R8: `mispredict` is high in the update cycle when the update is valid and either the outcome differs from `upd_pred_taken`, or the branch was taken and `upd_pred_target` differs from `upd_target`. `redirect_pc` is `upd_target` for a taken outcome and `upd_pc + 4` otherwise.
- R9: While `upd_valid` is low, no counter or target entry changes, whatever the other update inputs carry.
- R10: Consider a loop branch taken nine times and then not taken on its tenth execution. Once the predictor is warmed up, each run of the loop produces exactly one mispredict, at the loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Current fetch address |
| pred_taken | output | 1 | Fetch should follow the predicted target |
| pred_next_pc | output | PC_W | Next fetch address |
| upd_valid | input | 1 | Resolved-branch strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_target | input | PC_W | Actual taken target |
| upd_pred_taken | input | 1 | Direction fetch used for this branch |
| upd_pred_target | input | PC_W | Next address fetch used for this branch |
| mispredict | output | 1 | Flush request for the resolved branch |
| redirect_pc | output | PC_W | Correct restart address |

## Verification
Prediction outputs follow `fetch_pc` with no register in the path. `mispredict` and `redirect_pc` follow the update inputs in the same way. The bench therefore drives inputs just after a falling edge and samples them a nanosecond later, still inside that cycle. Training passes through one register, so the effect of an update appears only after the next rising edge. Each update is checked twice. It is checked before that edge, with fetch pointing at the same address, where the old value must still be seen. It is checked again after the edge, where the new value must be seen. A bench model of the counters and target entries, computed from the encoding rules, supplies every expected value.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Two-bit hysteresis states; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        CNT_SNT = 2'b00,
        CNT_WNT = 2'b01,
        CNT_WT  = 2'b10,
        CNT_ST  = 2'b11
    } cnt_e;

    localparam cnt_e CNT_INIT = CNT_WNT;

    function automatic cnt_e cnt_next(input cnt_e cur, input logic taken);
        cnt_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CNT_ST) nxt = cnt_e'(cur + 2'b01);
        end else begin
            if (cur != CNT_SNT) nxt = cnt_e'(cur - 2'b01);
        end
        return nxt;
    endfunction

    function automatic logic cnt_dir(input cnt_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    cnt_e tbl [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CNT_INIT;
        end else if (wr_en) begin
            tbl[wr_idx] <= cnt_next(tbl[wr_idx], wr_taken);
        end
    end

    assign rd_dir = cnt_dir(tbl[rd_idx]);
endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-3:0] rd_word,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    input  logic            wr_en,
    input  logic [PC_W-3:0] wr_word,
    input  logic [PC_W-1:0] wr_target
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned TAG_W = PC_W - 2 - IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [PC_W-1:0]  target;
    } entry_t;

    entry_t ents [DEPTH];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    entry_t           rd_ent;

    assign rd_idx = rd_word[IDX_W-1:0];
    assign rd_tag = rd_word[PC_W-3:IDX_W];
    assign wr_idx = wr_word[IDX_W-1:0];
    assign wr_tag = wr_word[PC_W-3:IDX_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_idx] <= '{valid: 1'b1, tag: wr_tag, target: wr_target};
        end
    end

    assign rd_ent    = ents[rd_idx];
    assign rd_hit    = rd_ent.valid && (rd_ent.tag == rd_tag);
    assign rd_target = rd_ent.target;
endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
    parameter int unsigned PC_W = 32
) (
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict,
    output logic [PC_W-1:0] redirect_pc
);
    logic dir_wrong, tgt_wrong;

    always_comb begin
        dir_wrong   = upd_taken != upd_pred_taken;
        tgt_wrong   = upd_taken && (upd_pred_target != upd_target);
        mispredict  = upd_valid && (dir_wrong || tgt_wrong);
        redirect_pc = upd_taken ? upd_target : upd_pc + PC_W'(4);
    end
endmodule

// File: rtl/branch_predictor.sv
module branch_predictor #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned DIR_IDX_W = 4,
    parameter int unsigned BTB_IDX_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_pred_taken,
    input  logic [PC_W-1:0] upd_pred_target,
    output logic            mispredict,
    output logic [PC_W-1:0] redirect_pc
);
    localparam int unsigned IDX_LO = 2;
    localparam int unsigned DIR_HI = DIR_IDX_W + IDX_LO - 1;

    logic            rd_dir;
    logic            tb_hit;
    logic [PC_W-1:0] tb_target;

    bp_dir_table #(.IDX_W(DIR_IDX_W)) u_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (fetch_pc[DIR_HI:IDX_LO]),
        .rd_dir   (rd_dir),
        .wr_en    (upd_valid),
        .wr_idx   (upd_pc[DIR_HI:IDX_LO]),
        .wr_taken (upd_taken)
    );

    bp_target_buf #(.PC_W(PC_W), .IDX_W(BTB_IDX_W)) u_tgt (
        .clk       (clk),
        .rst       (rst),
        .rd_word   (fetch_pc[PC_W-1:IDX_LO]),
        .rd_hit    (tb_hit),
        .rd_target (tb_target),
        .wr_en     (upd_valid && upd_taken),
        .wr_word   (upd_pc[PC_W-1:IDX_LO]),
        .wr_target (upd_target)
    );

    bp_resolve #(.PC_W(PC_W)) u_res (
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_taken       (upd_taken),
        .upd_target      (upd_target),
        .upd_pred_taken  (upd_pred_taken),
        .upd_pred_target (upd_pred_target),
        .mispredict      (mispredict),
        .redirect_pc     (redirect_pc)
    );

    assign pred_taken   = rd_dir && tb_hit;
    assign pred_next_pc = pred_taken ? tb_target : fetch_pc + PC_W'(4);
endmodule

// File: rtl/bp_checks.sv
module bp_checks #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic [PC_W-1:0] pred_next_pc,
    input logic            upd_valid,
    input logic            upd_taken,
    input logic [PC_W-1:0] upd_target,
    input logic            mispredict,
    input logic [PC_W-1:0] redirect_pc
);
    // R8
    flush_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> upd_valid);

    // R8
    taken_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        (mispredict && upd_taken) |-> (redirect_pc == upd_target));

    // R6
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> (pred_next_pc == fetch_pc + PC_W'(4)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_valid) && $stable(fetch_pc))
            |-> ($stable(pred_taken) && $stable(pred_next_pc)));

    // R2
    cold_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_taken);
endmodule

bind branch_predictor bp_checks #(.PC_W(PC_W)) u_chk (.*);

// File: tb/branch_predictor_test.sv
`timescale 1ns/1ps
module branch_predictor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0, upd_pred_target = '0;
    logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_pred_taken = 1'b0;
    logic        pred_taken, mispredict;
    logic [31:0] pred_next_pc, redirect_pc;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // Bench model: counters 0..3, target entries (index pc[4:2], tag pc[31:5])
    int          m_cnt [16];
    bit          m_bv  [8];
    logic [31:0] m_tag [8];
    logic [31:0] m_tgt [8];

    branch_predictor uut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic m_pt(input logic [31:0] pc);
        int d, b;
        d = int'((pc >> 2) & 32'hF);
        b = int'((pc >> 2) & 32'h7);
        return (m_cnt[d] >= 2) && m_bv[b] && (m_tag[b] == (pc >> 5));
    endfunction

    function automatic logic [31:0] m_np(input logic [31:0] pc);
        return m_pt(pc) ? m_tgt[int'((pc >> 2) & 32'h7)] : pc + 32'd4;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_fetch(input logic [31:0] pc, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check(pred_taken == m_pt(pc), req, 32'(pred_taken), 32'(m_pt(pc)));
        check(pred_next_pc == m_np(pc), req, pred_next_pc, m_np(pc));
    endtask

    task automatic model_update(input logic [31:0] pc, input bit taken, input logic [31:0] tgt);
        int d, b;
        d = int'((pc >> 2) & 32'hF);
        b = int'((pc >> 2) & 32'h7);
        m_cnt[d] = taken ? ((m_cnt[d] == 3) ? 3 : m_cnt[d] + 1)
                         : ((m_cnt[d] == 0) ? 0 : m_cnt[d] - 1);
        if (taken) begin
            m_bv[b] = 1'b1; m_tag[b] = pc >> 5; m_tgt[b] = tgt;
        end
    endtask

    // One resolved branch; fetch looks at the same address (R7).
    task automatic do_update(input logic [31:0] pc, input bit taken, input logic [31:0] tgt, input string req);
        logic        pt, exp_mis;
        logic [31:0] np, exp_red;
        pt = m_pt(pc);
        np = m_np(pc);
        @(negedge clk);
        fetch_pc = pc; upd_valid = 1'b1; upd_pc = pc; upd_taken = taken;
        upd_target = tgt; upd_pred_taken = pt; upd_pred_target = np;
        #1;
        exp_mis = (taken != pt) || (taken && np != tgt);
        exp_red = taken ? tgt : pc + 32'd4;
        check(pred_taken == pt, "R7 old value", 32'(pred_taken), 32'(pt));
        check(mispredict == exp_mis, "R8 mispredict", 32'(mispredict), 32'(exp_mis));
        check(redirect_pc == exp_red, "R8 redirect", redirect_pc, exp_red);
        @(posedge clk);
        model_update(pc, taken, tgt);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check(pred_taken == m_pt(pc), req, 32'(pred_taken), 32'(m_pt(pc)));
        check(pred_next_pc == m_np(pc), req, pred_next_pc, m_np(pc));
    endtask

    initial begin
        bit pat [10] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 1};
        for (int i = 0; i < 16; i++) m_cnt[i] = 1;
        for (int i = 0; i < 8; i++) begin m_bv[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R2: cold state, sequential fetch everywhere
        for (int i = 0; i < 16; i++) chk_fetch(32'h100 + 32'(i) * 4, "R2 reset state");

        // R3 / R4 / R2: per index training sweep with saturation and hysteresis
        for (int i = 0; i < 16; i++)
            for (int s = 0; s < 10; s++)
                do_update(32'h100 + 32'(i) * 4, pat[s], 32'h800 + 32'(i) * 16,
                          s == 0 ? "R2 first taken" : (s == 5 ? "R4 hysteresis" : "R3 counter"));

        // R9: strobe low, other inputs active
        @(negedge clk);
        upd_valid = 1'b0; upd_taken = 1'b1; upd_pc = 32'h104; upd_target = 32'hDEAD0;
        upd_pred_taken = 1'b0;
        #1 check(mispredict == 1'b0, "R9 no flush", 32'(mispredict), 32'h0);
        repeat (4) @(posedge clk);
        for (int i = 0; i < 16; i++) chk_fetch(32'h100 + 32'(i) * 4, "R9 unchanged");

        // R1 / R5 / R6: aliasing addresses 0x300 and 0x340 share a counter
        do_update(32'h300, 1'b1, 32'h900, "R5 install");
        do_update(32'h300, 1'b1, 32'h900, "R6 hit");
        chk_fetch(32'h340, "R1 R5 tag miss falls back");
        check(pred_taken == 1'b0, "R5 miss not taken", 32'(pred_taken), 32'h0);
        do_update(32'h340, 1'b1, 32'hA00, "R1 shared counter");
        chk_fetch(32'h340, "R6 new target");
        check(pred_next_pc == 32'hA00, "R6 target", pred_next_pc, 32'hA00);
        chk_fetch(32'h300, "R5 replaced entry");
        check(pred_next_pc == 32'h304, "R5 replaced", pred_next_pc, 32'h304);
        do_update(32'h300, 1'b0, 32'h0, "R5 not-taken keeps entry");
        chk_fetch(32'h340, "R5 entry kept");

        // R10: loop branch at 0x200, nine taken then exit, three runs
        for (int run = 0; run < 3; run++) begin
            int mis = 0;
            for (int it = 0; it < 10; it++) begin
                bit          tk = (it < 9);
                logic        p;
                logic [31:0] n;
                @(negedge clk);
                fetch_pc = 32'h200;
                #1 p = pred_taken; n = pred_next_pc;
                upd_valid = 1'b1; upd_pc = 32'h200; upd_taken = tk; upd_target = 32'h1C0;
                upd_pred_taken = p; upd_pred_target = n;
                #1 if (mispredict) mis++;
                @(posedge clk);
                model_update(32'h200, tk, 32'h1C0);
                @(negedge clk); upd_valid = 1'b0;
            end
            if (run > 0) check(mis == 1, "R10 one mispredict per loop", 32'(mis), 32'd1);
        end

        // R2: reset clears training
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 16; i++) m_cnt[i] = 1;
        for (int i = 0; i < 8; i++) m_bv[i] = 0;
        chk_fetch(32'h200, "R2 after reset");
        check(pred_next_pc == 32'h204, "R2 fallthrough", pred_next_pc, 32'h204);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule